// File: doc/BRIEF.md
# Timer/Counter and Watchdog with a Shared Prescaler

This block holds an 8-bit timer/counter and a free-running watchdog counter. One binary prescaler serves them, and it belongs to only one of the two at any time. A 6-bit configuration register sets four things: whether the timer counts the internal instruction cycle or an external input, which edge of that input counts, which unit owns the prescaler, and the division ratio. The unit that does not own the prescaler runs at its raw tick rate.

One instruction cycle lasts four clock phases. The external input is resampled on phase 1 and phase 3 of every cycle, and the block detects edges on the resampled value. The timer sets a sticky overflow flag when it rolls over. An interrupt request follows from that flag and an enable bit held in a small control register. Each write to the timer stops counting for two instruction cycles. The watchdog gives a one-clock reset pulse when its counter passes terminal count. Software restarts the watchdog with a clear strobe.

Top module: `tw_unit`

## Requirements
- R1: After reset the timer reads 0, the flag and the enable read 0, and `wdt_reset` is low. The configuration register resets to all ones: external source, falling edge, prescaler owned by the watchdog, ratio code 7. With no write to the configuration, the timer therefore counts falling edges of `ext_clk_in` one for one.
- R2: When the configuration selects the internal source (bit 5 = 0) and the prescaler is owned by the watchdog (bit 3 = 1), the timer adds 1 once per instruction cycle, which is 4 clocks.
- R3: When the prescaler is owned by the timer (bit 3 = 0), ratio code n in bits 2:0 makes the timer add 1 once every 2^(n+1) source events, from 1:2 up to 1:256.
- R4: A timer write loads `tmr_wdata`. It clears the prescaler count when the timer owns the prescaler, and it does not change the ownership. The first two instruction cycles after the write add nothing to the timer.
- R5: A rollover from FFh to 00h sets the flag. The flag stays set until a control write clears it. `irq` is high exactly while the flag and the enable are both 1.
- R6: When the external source is selected (bit 5 = 1), the timer counts edges of `ext_clk_in`. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The input is resampled on phases 1 and 3 of each 4-phase cycle, so it must stay high for at least 2 clocks and low for at least 2 clocks.
- R7: When the watchdog owns the prescaler, ratio code n divides its tick by 2^n, from 1:1 up to 1:128. When the 2^WDT_W-state counter wraps, `wdt_reset` is high for exactly one clock.
- R8: `wdt_clr` restarts the watchdog counter. It also clears the prescaler when the watchdog owns it. When the timer owns the prescaler, `wdt_clr` has no effect on timer counting.
- R9: A control write sets the enable from bit 1 and the flag from bit 0. If an overflow happens in the same cycle, the overflow wins and the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four clocks make one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 6 | Configuration data: [5] external source, [4] falling edge, [3] watchdog owns prescaler, [2:0] ratio |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control data: [1] interrupt enable, [0] overflow flag |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Value loaded into the timer |
| wdt_clr | input | 1 | Watchdog clear strobe |
| ext_clk_in | input | 1 | External count input, asynchronous |
| tmr_value | output | 8 | Current timer value |
| tmr_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request (flag and enable) |
| wdt_reset | output | 1 | One-clock watchdog reset pulse |

## Verification
The bench loads the timer and then counts ticks, and it compares the final count with a count of the ticks that can add to the timer. This catches an inhibit window that is too short or too long: at ratio 1:2 a correct design swallows the first prescaled tick, and a wrong one is off by one. The watchdog tests run the timer alongside as a time reference. One timer value combined with the flag tells a 1:1 watchdog ratio from a 1:2 ratio, which exposes an off-by-one in the 2^n mapping. Further tests clear the watchdog while the timer owns the prescaler, pulse a rollover with and without the enable, and flip the edge polarity while the input is held. A design that clears the wrong owner's prescaler, lets a control write beat the overflow, or counts the spurious edge made by a polarity change ends with a different count.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int RATIO_W = 3;
  localparam int PS_W    = 1 << RATIO_W;
  localparam int CFG_W   = 3 + RATIO_W;

  typedef struct packed {
    logic               ext_src;
    logic               edge_fall;
    logic               wdt_own;
    logic [RATIO_W-1:0] ratio;
  } tw_cfg_t;
endpackage

// File: rtl/tw_phase_gen.sv
module tw_phase_gen #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic instr_tick,
  output logic sample_stb
);
  localparam int NPH = 1 << PH_W;
  localparam logic [PH_W-1:0] LAST = PH_W'(NPH - 1);
  localparam logic [PH_W-1:0] MID  = PH_W'(NPH / 2 - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb ph_d = ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;

  assign instr_tick = (ph_q == LAST);
  assign sample_stb = (ph_q == LAST) || (ph_q == MID);
endmodule

// File: rtl/tw_ext_sync.sv
module tw_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic ext_in,
  input  logic edge_fall,
  output logic evt
);
  logic s1_q, s2_q, s1_d, s2_d;

  always_comb begin
    s1_d = sample_stb ? (ext_in ^ edge_fall) : s1_q;
    s2_d = sample_stb ? s1_q : s2_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end

  assign evt = sample_stb && s1_q && !s2_q;

  // R6: an edge event is only produced on a sampling phase, never twice in a row
  assert_evt_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler
  import tw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               evt,
  input  logic               wdt_mode,
  input  logic [RATIO_W-1:0] ratio,
  output logic               out_tick
);
  logic [PS_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    for (int i = 0; i < PS_W; i++)
      mask[i] = wdt_mode ? (i < int'(ratio)) : (i <= int'(ratio));
  end

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign out_tick = evt && ((cnt_q & mask) == mask);

  // R4: right after a clear in timer mode the divide-by-2 stage must block an output
  assert_clear_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wdt_mode || !out_tick));
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic rst_pulse
);
  logic [WDT_W-1:0] cnt_q, cnt_d;
  logic             pulse_d;

  always_comb begin
    pulse_d = tick && (cnt_q == '1) && !clr;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rst_pulse <= pulse_d;
    end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rst_pulse);
endmodule

// File: rtl/tw_unit.sv
module tw_unit
  import tw_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int WDT_W   = 8,
  parameter int PH_W    = 2,
  parameter int INHIBIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_wdata,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             wdt_clr,
  input  logic             ext_clk_in,
  output logic [TMR_W-1:0] tmr_value,
  output logic             tmr_flag,
  output logic             irq,
  output logic             wdt_reset
);
  localparam int INH_W = $clog2(INHIBIT + 1);

  tw_cfg_t          cfg_q, cfg_d;
  logic             en_q, en_d, flag_q, flag_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [INH_W-1:0] inh_q, inh_d;
  logic instr_tick, sample_stb, ext_evt, src_evt;
  logic ps_evt, ps_clr, ps_out, tmr_tick, wdt_tick, tmr_inc, ovf;

  tw_phase_gen #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick), .sample_stb(sample_stb));

  tw_ext_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .ext_in(ext_clk_in),
    .edge_fall(cfg_q.edge_fall), .evt(ext_evt));

  always_comb begin
    src_evt  = cfg_q.ext_src ? ext_evt : instr_tick;
    ps_evt   = cfg_q.wdt_own ? instr_tick : src_evt;
    ps_clr   = cfg_q.wdt_own ? wdt_clr : tmr_we;
    tmr_tick = cfg_q.wdt_own ? src_evt : ps_out;
    wdt_tick = cfg_q.wdt_own ? ps_out : instr_tick;
  end

  tw_prescaler u_ps (
    .clk(clk), .rst_n(rst_n), .clr(ps_clr), .evt(ps_evt),
    .wdt_mode(cfg_q.wdt_own), .ratio(cfg_q.ratio), .out_tick(ps_out));

  tw_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .clr(wdt_clr), .tick(wdt_tick), .rst_pulse(wdt_reset));

  always_comb begin
    tmr_inc = tmr_tick && !tmr_we && (inh_q == '0);
    ovf     = tmr_inc && (tmr_q == '1);
    cfg_d   = cfg_we ? tw_cfg_t'(cfg_wdata) : cfg_q;
    en_d    = ctl_we ? ctl_wdata[1] : en_q;
    flag_d  = (ctl_we ? ctl_wdata[0] : flag_q) | ovf;
    if (tmr_we) begin
      tmr_d = tmr_wdata;
      inh_d = INH_W'(INHIBIT);
    end else begin
      tmr_d = tmr_inc ? tmr_q + 1'b1 : tmr_q;
      inh_d = (instr_tick && inh_q != '0) ? inh_q - 1'b1 : inh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= '1;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      tmr_q  <= '0;
      inh_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      tmr_q  <= tmr_d;
      inh_q  <= inh_d;
    end

  assign tmr_value = tmr_q;
  assign tmr_flag  = flag_q;
  assign irq       = flag_q & en_q;

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_value == $past(tmr_wdata));
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q != '0 && !tmr_we) |=> $stable(tmr_value));
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_value == $past(tmr_value) ||
                 tmr_value == TMR_W'($past(tmr_value) + 1'b1)));
  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_value == '0 && $past(tmr_value) == '1 && !$past(tmr_we)) |-> tmr_flag);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !ctl_we) |=> tmr_flag);
endmodule

// File: tb/test_tw_unit.sv
module test_tw_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = '0;
  logic       tmr_we = 1'b0;
  logic [7:0] tmr_wdata = '0;
  logic       wdt_clr = 1'b0;
  logic       ext_clk_in = 1'b1;
  logic [7:0] tmr_value;
  logic       tmr_flag, irq, wdt_reset;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tw_unit i_tw_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .wdt_clr(wdt_clr), .ext_clk_in(ext_clk_in), .tmr_value(tmr_value),
    .tmr_flag(tmr_flag), .irq(irq), .wdt_reset(wdt_reset));

  typedef struct packed {
    logic [5:0] cfg;
    logic [7:0] init;
    logic [7:0] cycles;
    logic [7:0] fin;
  } vec_t;

  // internal source; fin = init + ticks that reach the timer after the 2-cycle inhibit
  localparam vec_t VECS [6] = '{
    '{6'b000000, 8'h10, 8'd10, 8'h14},  // R3 1:2, first prescaled tick swallowed
    '{6'b000001, 8'h20, 8'd20, 8'h25},  // R3 1:4
    '{6'b000010, 8'hF0, 8'd40, 8'hF5},  // R3 1:8
    '{6'b000011, 8'h00, 8'd64, 8'h04},  // R3 1:16
    '{6'b001111, 8'h30, 8'd10, 8'h38},  // R2 unscaled timer
    '{6'b001000, 8'h7F, 8'd3,  8'h80}   // R2 R4 short window
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [5:0] v);
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [1:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_we = 1'b1; tmr_wdata = v; @(negedge clk); tmr_we = 1'b0;
  endtask

  task automatic pulses(input int n, input logic lvl);
    for (int i = 0; i < n; i++) begin
      ext_clk_in = lvl; wait_clk(4);
      ext_clk_in = ~lvl; wait_clk(4);
    end
  endtask

  task automatic wdt_run(input logic [5:0] cfg, input logic exp_flag, input string req);
    bit seen = 0;
    wr_cfg(cfg);
    wr_ctl(2'b00);
    tmr_we = 1'b1; tmr_wdata = 8'h00; wdt_clr = 1'b1;
    @(negedge clk);
    tmr_we = 1'b0; wdt_clr = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (wdt_reset) seen = 1;
    end
    chk({req, " pulse seen"}, 32'(seen), 32'd1);
    chk({req, " timer at pulse"}, 32'(tmr_value), 32'hFE);
    chk({req, " flag at pulse"}, 32'(tmr_flag), 32'(exp_flag));
    @(negedge clk);
    chk({req, " pulse one clock"}, 32'(wdt_reset), 32'd0);
  endtask

  initial begin
    bit seen;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(40);
    chk("R1 timer reset", 32'(tmr_value), 32'h00);
    chk("R1 flag reset", 32'(tmr_flag), 32'd0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 wdt_reset idle", 32'(wdt_reset), 32'd0);
    pulses(3, 1'b0);
    wait_clk(8);
    chk("R1 default counts falling edges", 32'(tmr_value), 32'h03);

    for (int k = 0; k < 6; k++) begin
      wr_cfg(VECS[k].cfg);
      wr_tmr(VECS[k].init);
      wait_clk(4 * int'(VECS[k].cycles));
      chk($sformatf("R3 R4 vector %0d", k), 32'(tmr_value), 32'(VECS[k].fin));
    end

    // R5 R9 overflow and interrupt gating
    wr_cfg(6'b001000);
    wr_ctl(2'b10);
    wr_tmr(8'hFD);
    wait_clk(16);
    chk("R5 before wrap", 32'(tmr_value), 32'hFF);
    chk("R5 flag clear before wrap", 32'(tmr_flag), 32'd0);
    wait_clk(4);
    chk("R5 wrapped", 32'(tmr_value), 32'h00);
    chk("R5 flag set", 32'(tmr_flag), 32'd1);
    chk("R5 irq with enable", 32'(irq), 32'd1);
    wr_ctl(2'b01);
    chk("R9 enable off masks irq", 32'(irq), 32'd0);
    chk("R9 flag kept", 32'(tmr_flag), 32'd1);
    wr_ctl(2'b10);
    wait_clk(8);
    chk("R9 flag cleared by write", 32'(tmr_flag), 32'd0);

    // R8 watchdog clear while the timer owns the prescaler (1:4)
    wr_cfg(6'b000001);
    wr_tmr(8'h00);
    wait_clk(24);
    wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
    wait_clk(55);
    chk("R8 wdt_clr leaves timer prescaler", 32'(tmr_value), 32'h05);

    // R7 watchdog ratios 1:1 and 1:2, timer used as time reference
    wdt_run(6'b001000, 1'b0, "R7 ratio 1:1");
    wdt_run(6'b001001, 1'b1, "R7 ratio 1:2");

    // R8 periodic clears hold off the watchdog
    wr_cfg(6'b001000);
    seen = 0;
    for (int j = 0; j < 3; j++) begin
      wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0;
      for (int i = 0; i < 800; i++) begin
        @(negedge clk);
        if (wdt_reset) seen = 1;
      end
    end
    chk("R8 no pulse with periodic clears", 32'(seen), 32'd0);

    // R6 external rising edges
    ext_clk_in = 1'b0; wait_clk(8);
    wr_cfg(6'b101000);
    wr_tmr(8'h00);
    wait_clk(12);
    pulses(5, 1'b1);
    wait_clk(8);
    chk("R6 rising edges counted", 32'(tmr_value), 32'h05);

    // R6 external falling edges, polarity flipped while input high
    ext_clk_in = 1'b1; wait_clk(8);
    wr_cfg(6'b111000);
    wr_tmr(8'h00);
    wait_clk(12);
    pulses(5, 1'b0);
    wait_clk(8);
    chk("R6 falling edges counted", 32'(tmr_value), 32'h05);

    // R3 R6 external edges through timer prescaler 1:2
    wr_cfg(6'b100000);
    wr_tmr(8'h00);
    wait_clk(12);
    ext_clk_in = 1'b0; wait_clk(8);
    pulses(8, 1'b1);
    wait_clk(8);
    chk("R3 R6 prescaled external", 32'(tmr_value), 32'h04);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule